// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write an asynchronous byte-wide static RAM that has active-low chip enable, write enable and output enable strobes. The host presents one request at a time (address, write flag, write data) and the controller accepts it when its ready output is high. It then drives the address and the strobes, and switches its own data drivers on and off, in a fixed sequence. Every memory timing minimum is given as a parameter in nanoseconds together with the clock period. Each minimum is converted to whole clock cycles, rounded up.

Writes are controlled by write enable. Output enable is held high for the whole write, so the short write pulse rule applies and the pulse never has to cover the memory's output turn-off time. Reads hold chip enable and output enable low and write enable high. They wait until the slowest of the address, chip-enable and output-enable access times has passed, then capture the data bus and return it with a one-cycle valid pulse. If the minimum read cycle is longer than the access window, a quiet tail follows with the strobes inactive before the next request is taken.

All memory-side outputs come straight from flip-flops. The data bus is split into an output value, an output enable and an input, so the tri-state pad can sit at the chip edge.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and while idle, chip enable, write enable and output enable are all high (inactive, 1), the data drive enable is 0, ready is 1 and read-data-valid is 0.
- R2: In a write, the address and chip enable (low) are set S = max(1, ceil(tAS)) cycles before write enable falls. Write enable stays low for P cycles, chip enable is low for every cycle that write enable is low, and write enable is high in the cycle before and the cycle after every change of the address.
- R3: During a write, output enable stays high. The data drive enable rises only in a cycle after write enable went low, and falls only when write enable has already been high for at least ceil(tDH) cycles.
- R4: The write-enable low time is at least tWP ns, and the driven write data is stable for at least tDS ns before write enable rises. So P = max(ceil(tWP), ceil(tDS)+1, 2, max(ceil(tAW), ceil(tCW)) - S).
- R5: A write keeps ready low for exactly S + P + H cycles after acceptance, where H = max(1, ceil(tDH), ceil(tWR), ceil(tWC) - S - P). Chip enable returns high at the end.
- R6: A read drives chip enable and output enable low with write enable high. It captures the data input RA = max(1, ceil(tAA), ceil(tOE), ceil(tACE)) cycles after acceptance and asserts read-data-valid for exactly one cycle with that byte. The read data output changes only together with read-data-valid.
- R7: A read keeps ready low for max(RA, ceil(tRC)) cycles after acceptance, with all strobes high during any cycles after the capture.
- R8: A byte written to an address is returned by a later read of that address, for every address, and a later write to the same address replaces it.
- R9: A request is accepted only in a cycle where both request-valid and ready are high. A request held valid while the controller is busy does not alter the address or data of the access in progress, and is taken once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Memory address of the request |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: rsp_rdata holds read data |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data value for the bus driver |
| mem_dq_oe | output | 1 | Bus driver enable, 1 = drive |
| mem_dq_i | input | DATA_W | Data bus as received from the pad |

## Verification
A sequencer stuck in the wrong phase or with a wrong count shows at the ports within one access. The ready-low window, the write-enable pulse width or the capture cycle lands off its computed cycle number. If the capture comes too early, the bench's memory model is still returning poison at that point, so the byte that comes back is wrong. A driver enable or address update that slips past the write-enable edges is seen within one cycle as a strobe-ordering violation on the memory side. A datapath latch fault appears on the next read-back of the address it corrupted, which is why every address is written and then read back.

// File: rtl/sram_ctl_pkg.sv
// Shared definitions for the SRAM access controller: phase encoding and
// nanosecond-to-cycle helpers used to size every phase at elaboration.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WPUL  = 3'd2,
        ST_WHLD  = 3'd3,
        ST_RACC  = 3'd4,
        ST_RTAIL = 3'd5
    } phase_t;

    // Whole cycles covering a nanosecond minimum; zero stays zero.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns <= 0) ? 0 : (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Phase length counter. Assumes the sequencer loads (length-1) at the edge
// that enters a phase; done is high in the last cycle of that phase.
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctl_datapath.sv
// Request latch and read capture. Assumes accept and sample are single-cycle
// strobes from the sequencer; address and write data change only on accept.
module sram_ctl_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Hold address and write byte for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Capture the bus at the end of the read window and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sample;
            if (sample) begin
                rsp_rdata <= mem_dq_i;
            end
        end
    end

    p_rdata_moves_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_valid);

endmodule

// File: rtl/sram_ctl_fsm.sv
// Access sequencer. Walks idle -> setup -> pulse -> hold for writes and
// idle -> access -> optional tail for reads. Every strobe is a flip-flop.
// Assumes the phase lengths are at least 1 and the pulse length at least 2.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int S_LEN    = 1,
    parameter int P_LEN    = 2,
    parameter int H_LEN    = 1,
    parameter int RA_LEN   = 1,
    parameter int TAIL_LEN = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_done,
    output logic             req_ready,
    output logic             accept,
    output logic             sample,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic             mem_dq_oe
);

    localparam logic [CNT_W-1:0] S_LD  = CNT_W'(S_LEN - 1);
    localparam logic [CNT_W-1:0] P_LD  = CNT_W'(P_LEN - 1);
    localparam logic [CNT_W-1:0] H_LD  = CNT_W'(H_LEN - 1);
    localparam logic [CNT_W-1:0] RA_LD = CNT_W'(RA_LEN - 1);
    localparam logic [CNT_W-1:0] T_LD  = (TAIL_LEN > 0) ? CNT_W'(TAIL_LEN - 1) : '0;
    localparam bit HAS_TAIL = (TAIL_LEN > 0);

    phase_t state;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign sample    = (state == ST_RACC) && timer_done;

    // Phase length to load at each phase entry.
    always_comb begin
        timer_load = 1'b0;
        timer_val  = '0;
        case (state)
            ST_IDLE: if (accept) begin
                timer_load = 1'b1;
                timer_val  = req_write ? S_LD : RA_LD;
            end
            ST_WSET: if (timer_done) begin
                timer_load = 1'b1;
                timer_val  = P_LD;
            end
            ST_WPUL: if (timer_done) begin
                timer_load = 1'b1;
                timer_val  = H_LD;
            end
            ST_RACC: if (timer_done && HAS_TAIL) begin
                timer_load = 1'b1;
                timer_val  = T_LD;
            end
            default: ;
        endcase
    end

    // Phase transitions and registered strobe / driver control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    mem_ce_n <= 1'b0;
                    if (req_write) begin
                        state <= ST_WSET;
                    end else begin
                        mem_oe_n <= 1'b0;
                        state    <= ST_RACC;
                    end
                end
                ST_WSET: if (timer_done) begin
                    mem_we_n <= 1'b0;
                    state    <= ST_WPUL;
                end
                ST_WPUL: begin
                    mem_dq_oe <= 1'b1;
                    if (timer_done) begin
                        mem_we_n <= 1'b1;
                        state    <= ST_WHLD;
                    end
                end
                ST_WHLD: if (timer_done) begin
                    mem_ce_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                    state     <= ST_IDLE;
                end
                ST_RACC: if (timer_done) begin
                    mem_ce_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                    state    <= HAS_TAIL ? ST_RTAIL : ST_IDLE;
                end
                ST_RTAIL: if (timer_done) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_ce_low_under_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

endmodule

// File: rtl/sram_ctl.sv
// Asynchronous SRAM access controller top. Converts nanosecond minimums to
// phase lengths and wires sequencer, phase timer and datapath. Assumes one
// outstanding request and a memory that is only ever touched by this block.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 4,
    parameter int T_AS   = 0,
    parameter int T_WP   = 40,
    parameter int T_DS   = 25,
    parameter int T_DH   = 0,
    parameter int T_AW   = 50,
    parameter int T_CW   = 50,
    parameter int T_WR   = 0,
    parameter int T_WC   = 55,
    parameter int T_AA   = 55,
    parameter int T_ACE  = 55,
    parameter int T_OE   = 35,
    parameter int T_RC   = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int S_LEN  = imax(1, ns_to_cyc(T_AS, CLK_NS));
    localparam int P_LEN  = imax(imax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DS, CLK_NS) + 1),
                                 imax(2, imax(ns_to_cyc(T_AW, CLK_NS),
                                              ns_to_cyc(T_CW, CLK_NS)) - S_LEN));
    localparam int H_LEN  = imax(imax(1, ns_to_cyc(T_DH, CLK_NS)),
                                 imax(ns_to_cyc(T_WR, CLK_NS),
                                      ns_to_cyc(T_WC, CLK_NS) - S_LEN - P_LEN));
    localparam int RA_LEN = imax(imax(1, ns_to_cyc(T_AA, CLK_NS)),
                                 imax(ns_to_cyc(T_OE, CLK_NS), ns_to_cyc(T_ACE, CLK_NS)));
    localparam int T_LEN  = imax(0, ns_to_cyc(T_RC, CLK_NS) - RA_LEN);
    localparam int MAXLEN = imax(imax(S_LEN, P_LEN), imax(H_LEN, imax(RA_LEN, T_LEN)));
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    logic             accept;
    logic             sample;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;

    sram_ctl_fsm #(
        .CNT_W    (CNT_W),
        .S_LEN    (S_LEN),
        .P_LEN    (P_LEN),
        .H_LEN    (H_LEN),
        .RA_LEN   (RA_LEN),
        .TAIL_LEN (T_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .timer_done (timer_done),
        .req_ready  (req_ready),
        .accept     (accept),
        .sample     (sample),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sample    (sample),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    p_we_high_on_addr_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |-> (mem_we_n && $past(mem_we_n)));

    p_drive_after_we_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(!mem_we_n) && !mem_we_n));

    p_release_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> ($past(mem_we_n) && mem_we_n));

    p_valid_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_ctl_tb_top.sv
// Bench: cycle-level SRAM model with timing checks, exhaustive write then
// read-back over a 256-byte configuration, overwrite and busy-hold cases.
module sram_ctl_tb_top;

    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int CLK   = 4;
    localparam int T_AS  = 0;
    localparam int T_WP  = 40;
    localparam int T_DS  = 25;
    localparam int T_DH  = 5;
    localparam int T_AW  = 50;
    localparam int T_CW  = 50;
    localparam int T_WR  = 10;
    localparam int T_WC  = 55;
    localparam int T_AA  = 55;
    localparam int T_ACE = 55;
    localparam int T_OE  = 35;
    localparam int T_RC  = 70;

    function automatic int cy(input int ns);
        return (ns + CLK - 1) / CLK;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths from the requirement formulas.
    localparam int E_S  = mx(1, cy(T_AS));
    localparam int E_P  = mx(mx(cy(T_WP), cy(T_DS) + 1), mx(2, mx(cy(T_AW), cy(T_CW)) - E_S));
    localparam int E_H  = mx(mx(1, cy(T_DH)), mx(cy(T_WR), cy(T_WC) - E_S - E_P));
    localparam int E_RA = mx(mx(1, cy(T_AA)), mx(cy(T_OE), cy(T_ACE)));
    localparam int E_RB = mx(E_RA, cy(T_RC));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .T_AS(T_AS), .T_WP(T_WP),
        .T_DS(T_DS), .T_DH(T_DH), .T_AW(T_AW), .T_CW(T_CW), .T_WR(T_WR),
        .T_WC(T_WC), .T_AA(T_AA), .T_ACE(T_ACE), .T_OE(T_OE), .T_RC(T_RC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Memory model, sampled away from the clock edge.
    logic [DW-1:0] model [256];
    int cyc = 0;
    int t_addr = 0, t_wefall = 0, t_werise = 0, t_data = 0, t_oefall = 0, t_cefall = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq_o = '0;
    logic p_ce_n = 1'b1, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_addr != p_addr) begin
                chk(mem_we_n && p_we_n, "R2 write enable high across address change", int'(mem_we_n), 1);
                t_addr = cyc;
            end
            if (p_ce_n && !mem_ce_n) t_cefall = cyc;
            if (p_oe_n && !mem_oe_n) t_oefall = cyc;
            if (p_we_n && !mem_we_n) begin
                t_wefall = cyc;
                chk(!mem_ce_n, "R2 chip enable low with write enable", int'(mem_ce_n), 0);
                chk(mem_oe_n, "R3 output enable high in write", int'(mem_oe_n), 1);
                chk(cyc - t_cefall == E_S, "R2 setup cycles", cyc - t_cefall, E_S);
            end
            if (!p_dq_oe && mem_dq_oe) begin
                chk(!mem_we_n && cyc > t_wefall, "R3 drive starts after write enable low",
                    cyc - t_wefall, 1);
                t_data = cyc;
            end
            if (!p_we_n && mem_we_n) begin
                t_werise = cyc;
                chk((cyc - t_wefall) * CLK >= T_WP, "R4 write pulse ns", (cyc - t_wefall) * CLK, T_WP);
                chk(cyc - t_wefall == E_P, "R2 write pulse cycles", cyc - t_wefall, E_P);
                chk(p_dq_oe && (cyc - t_data) * CLK >= T_DS, "R4 data setup ns",
                    (cyc - t_data) * CLK, T_DS);
                chk(mem_dq_oe, "R3 drive held past write end", int'(mem_dq_oe), 1);
                model[p_addr] = p_dq_o;
            end
            if (p_dq_oe && !mem_dq_oe) begin
                chk(mem_we_n && (cyc - t_werise) * CLK >= T_DH, "R3 drive release after hold",
                    (cyc - t_werise) * CLK, T_DH);
            end
            if (!mem_ce_n && !mem_oe_n && mem_we_n &&
                (cyc - t_addr + 1) * CLK >= T_AA && (cyc - t_oefall + 1) * CLK >= T_OE &&
                (cyc - t_cefall + 1) * CLK >= T_ACE)
                mem_dq_i <= model[mem_addr];
            else
                mem_dq_i <= ~model[mem_addr];
        end
        p_addr = mem_addr; p_dq_o = mem_dq_o; p_ce_n = mem_ce_n;
        p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
    end

    // One host access, called at a negedge with the controller idle.
    task automatic access(input bit wr, input int a, input int d,
                          output int busy, output int rv_at, output int rd, output int rv_cnt);
        int k;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; rv_cnt = 0; rv_at = -1; rd = -1;
        forever begin
            if (rsp_valid) begin rv_cnt++; rv_at = k - 1; rd = int'(rsp_rdata); end
            if (req_ready || k > 100) break;
            @(negedge clk);
            k++;
        end
        busy = k - 1;
    endtask

    function automatic int pat1(input int a);
        return (a * 29 + 7) & 8'hFF;
    endfunction

    initial begin
        int busy, rv_at, rd, rv_cnt;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(req_ready, "R1 ready in reset", int'(req_ready), 1);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
            int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        chk(!mem_dq_oe, "R1 drive off in reset", int'(mem_dq_oe), 0);
        chk(!rsp_valid, "R1 valid low in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 idle after reset", int'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 30);

        // R5 R8 write every address
        for (int a = 0; a < 256; a++) begin
            access(1'b1, a, pat1(a), busy, rv_at, rd, rv_cnt);
            chk(busy == E_S + E_P + E_H, "R5 write busy cycles", busy, E_S + E_P + E_H);
            chk(rv_cnt == 0, "R5 no read valid on write", rv_cnt, 0);
        end
        // R6 R7 R8 read every address, descending
        for (int a = 255; a >= 0; a--) begin
            access(1'b0, a, 0, busy, rv_at, rd, rv_cnt);
            chk(rv_cnt == 1, "R6 single valid pulse", rv_cnt, 1);
            chk(rv_at == E_RA, "R6 capture cycle", rv_at, E_RA);
            chk(rd == pat1(a), "R8 read back", rd, pat1(a));
            chk(busy == E_RB, "R7 read busy cycles", busy, E_RB);
        end
        // R7 strobes quiet after capture: check within the tail
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (E_RA) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !req_ready, "R7 tail strobes high",
            int'({mem_ce_n, mem_oe_n, mem_we_n, req_ready}), 14);
        while (!req_ready) @(negedge clk);

        // R8 overwrite and repeated same-address accesses
        access(1'b1, 8'h55, 8'hA3, busy, rv_at, rd, rv_cnt);
        access(1'b1, 8'h55, 8'h3C, busy, rv_at, rd, rv_cnt);
        access(1'b0, 8'h55, 0, busy, rv_at, rd, rv_cnt);
        chk(rd == 8'h3C, "R8 overwrite", rd, 8'h3C);
        access(1'b0, 8'h55, 0, busy, rv_at, rd, rv_cnt);
        chk(rd == 8'h3C && rv_at == E_RA, "R6 repeated read same address", rd, 8'h3C);

        // R9 request held valid during a busy write
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h21; req_wdata = 8'h9D;
        @(negedge clk);
        req_write = 1'b0; req_addr = 8'h22; req_wdata = 8'h44;
        busy = 1;
        while (!req_ready) begin
            chk(mem_addr == 8'h21 && mem_dq_o == 8'h9D, "R9 busy access unchanged",
                int'(mem_addr), 8'h21);
            @(negedge clk);
            busy++;
        end
        chk(busy - 1 == E_S + E_P + E_H, "R9 held request waits", busy - 1, E_S + E_P + E_H);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_addr == 8'h22 && !mem_oe_n, "R9 held request taken", int'(mem_addr), 8'h22);
        while (!req_ready) begin
            if (rsp_valid) chk(rsp_rdata == pat1(8'h22), "R9 held read data",
                               int'(rsp_rdata), pat1(8'h22));
            @(negedge clk);
        end
        access(1'b0, 8'h21, 0, busy, rv_at, rd, rv_cnt);
        chk(rd == 8'h9D, "R9 busy write stored", rd, 8'h9D);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule